// File: doc/BRIEF.md
# T1/J1 Superframe Framing-Bit Generator

This block sits in the transmit path of a T1 or J1 line and inserts the framing bit of a 12-frame superframe into a 193-bit-per-frame serial stream. Upstream timing supplies a frame strobe and a bit counter. The payload arrives one bit per cycle on `data_i`. The block returns the same stream on `data_o`, one cycle later, with the framing bit and a few payload positions overridden.

The framing bit follows a fixed 12-frame alignment sequence. T1 and J1 share that sequence, except that in J1 the last frame's bit carries the yellow alarm. In T1 the yellow alarm is sent instead by forcing bit 2 of every channel low. Three diagnostic aids are provided. A one-shot inversion of an odd-frame framing bit, a one-shot inversion of an even-frame framing bit, and a mimic copy of the framing bit into the following bit position. A single enable turns all framing actions off, and the F-bit slot then carries the payload.

Top module: `sf_fbit_gen`

## Requirements
- R1: In T1 mode (`mode_j1_i`=0) with framing enabled, the F-bit (bit counter 0) of superframe frames 1..12 is 1,0,0,0,1,1,0,1,1,1,0,0 in that order.
- R2: In J1 mode (`mode_j1_i`=1) with framing enabled, frames 1..11 use the same F-bits as R1, and the frame-12 F-bit is 1 while yellow is active and 0 otherwise.
- R3: In T1 mode while yellow is active, every bit-2-of-channel position (bit counter 8c+2, c=0..23) is sent as 0. In J1 mode these positions pass `data_i` unchanged.
- R4: Yellow is active when `yel_force_i`=1, or when `yel_auto_i`=1 and `red_alarm_i`=1. If `yel_auto_i`=1 and `red_alarm_i`=0, no yellow is sent.
- R5: A rising edge on `ft_inv_i` arms one inversion. The next odd-frame (1,3,..,11) F-bit sent with framing enabled is inverted, and the request then clears. Holding the input high inverts nothing further.
- R6: A rising edge on `fs_inv_i` arms one inversion. The next even-frame (2,4,..,12) F-bit sent with framing enabled is inverted, and the request then clears.
- R7: With framing and `mimic_en_i` enabled, the bit at counter 1 is sent equal to the F-bit just sent, including any inversion.
- R8: With framing disabled (`frm_en_i`=0), the F-bit and counter-1 positions pass `data_i`. No inversion is applied, and an armed inversion stays pending until framing is enabled again.
- R9: The frame index advances on each `frame_strobe_i` (given with bit counter 0) and wraps from frame 12 to frame 1. After reset or a `sync_rst_i` pulse, the next strobe starts frame 1.
- R10: `data_o` is registered, so it shows the result for the inputs of the previous cycle. It is 0 during reset.
- R11: All other positions (counter 2..192 except bit 2 of each channel, plus bit-2 positions when no T1 yellow applies) pass `data_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_rst_i | input | 1 | Synchronous superframe restart |
| frame_strobe_i | input | 1 | Frame start, asserted with bit counter 0 |
| bit_cnt_i | input | 8 | Bit position in frame, 0..192 (0 = F-bit) |
| data_i | input | 1 | Payload bit stream |
| mode_j1_i | input | 1 | 0 = T1, 1 = J1 |
| frm_en_i | input | 1 | Framing enable |
| mimic_en_i | input | 1 | Mimic bit insertion enable |
| yel_force_i | input | 1 | Manual yellow alarm |
| yel_auto_i | input | 1 | Automatic yellow on red alarm |
| red_alarm_i | input | 1 | Receive red alarm declared |
| ft_inv_i | input | 1 | Odd-frame F-bit inversion request (edge) |
| fs_inv_i | input | 1 | Even-frame F-bit inversion request (edge) |
| data_o | output | 1 | Output stream with framing inserted |

## Verification
The bound checker watches, on every cycle, these behaviours:
- the T1 yellow forcing of channel bit 2;
- the pass-through of plain payload positions, and of the F-bit slot while framing is disabled;
- the J1 frame-12 yellow bit;
- the mimic copy;
- the frame-index wrap;
- the rule that an armed inversion persists until a matching F-bit consumes it.

Three behaviours need the bench's scenarios: the exact 12-frame alignment sequence, that each request edge yields exactly one inverted bit, and that a pending request survives a framing-disabled interval and lands on the correct frame afterwards. The scoreboard model covers each of these.

// File: rtl/sf_fbit_pkg.sv
package sf_fbit_pkg;

  typedef enum logic [1:0] {
    POS_FBIT  = 2'd0,
    POS_MIMIC = 2'd1,
    POS_YEL   = 2'd2,
    POS_DATA  = 2'd3
  } pos_kind_e;

  // alignment sequence, frame 1 in the MSB
  localparam logic [11:0] SF_ALIGN = 12'b1000_1101_1100;

  function automatic logic align_bit(input logic [3:0] k);
    if (k > 4'd11) return 1'b0;
    return SF_ALIGN[4'd11 - k];
  endfunction

endpackage

// File: rtl/sf_frame_cnt.sv
module sf_frame_cnt #(
  parameter int N_FRAMES = 12,
  localparam int FW = $clog2(N_FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_rst_i,
  input  logic          strobe_i,
  output logic [FW-1:0] frame_q_o,
  output logic [FW-1:0] nxt_o
);

  localparam logic [FW-1:0] LAST = FW'(N_FRAMES - 1);

  logic [FW-1:0] frame_q;

  assign nxt_o     = (frame_q == LAST) ? '0 : frame_q + FW'(1);
  assign frame_q_o = frame_q;

  // parked on last frame so the first strobe lands on frame 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         frame_q <= LAST;
    else if (sync_rst_i) frame_q <= LAST;
    else if (strobe_i)   frame_q <= nxt_o;
  end

endmodule

// File: rtl/sf_err_req.sv
module sf_err_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic hit_i,
  output logic pend_o
);

  logic req_q;
  logic pend_q;
  logic rise;

  assign rise   = req_i & ~req_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q <= req_i;
      if (rise)       pend_q <= 1'b1;
      else if (hit_i) pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sf_pos_dec.sv
module sf_pos_dec
  import sf_fbit_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int CH_BITS    = 8,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic [CNT_W-1:0] bit_cnt_i,
  output pos_kind_e        kind_o
);

  logic [CNT_W-1:0] ch_off;

  assign ch_off = bit_cnt_i - CNT_W'(1);

  always_comb begin
    if (bit_cnt_i == '0)
      kind_o = POS_FBIT;
    else if (bit_cnt_i == CNT_W'(1))
      kind_o = POS_MIMIC;
    else if (bit_cnt_i < CNT_W'(FRAME_BITS) &&
             (ch_off % CNT_W'(CH_BITS)) == CNT_W'(1))
      kind_o = POS_YEL;
    else
      kind_o = POS_DATA;
  end

endmodule

// File: rtl/sf_fbit_gen.sv
module sf_fbit_gen
  import sf_fbit_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int N_FRAMES   = 12,
  parameter int CH_BITS    = 8,
  localparam int CNT_W = $clog2(FRAME_BITS),
  localparam int FW    = $clog2(N_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_rst_i,
  input  logic             frame_strobe_i,
  input  logic [CNT_W-1:0] bit_cnt_i,
  input  logic             data_i,
  input  logic             mode_j1_i,
  input  logic             frm_en_i,
  input  logic             mimic_en_i,
  input  logic             yel_force_i,
  input  logic             yel_auto_i,
  input  logic             red_alarm_i,
  input  logic             ft_inv_i,
  input  logic             fs_inv_i,
  output logic             data_o
);

  localparam logic [FW-1:0] LAST = FW'(N_FRAMES - 1);

  pos_kind_e     kind;
  logic [FW-1:0] frame_q;
  logic [FW-1:0] nxt_frame;
  logic [FW-1:0] cur_frame;
  logic          yel_w;
  logic          odd_frame;
  logic          align;
  logic          inv_sel;
  logic          fbit;
  logic          is_f;
  logic [1:0]    inv_req;
  logic [1:0]    hit;
  logic [1:0]    pend;
  logic          f_last_q;
  logic          data_d;

  sf_frame_cnt #(.N_FRAMES(N_FRAMES)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_rst_i(sync_rst_i),
    .strobe_i  (frame_strobe_i),
    .frame_q_o (frame_q),
    .nxt_o     (nxt_frame)
  );

  sf_pos_dec #(.FRAME_BITS(FRAME_BITS), .CH_BITS(CH_BITS)) u_pos (
    .bit_cnt_i(bit_cnt_i),
    .kind_o   (kind)
  );

  // index 0: odd-frame request, index 1: even-frame request
  assign inv_req = {fs_inv_i, ft_inv_i};

  for (genvar gi = 0; gi < 2; gi++) begin : g_req
    sf_err_req u_req (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (inv_req[gi]),
      .hit_i (hit[gi]),
      .pend_o(pend[gi])
    );
  end

  assign yel_w     = yel_force_i | (yel_auto_i & red_alarm_i);
  assign cur_frame = frame_strobe_i ? nxt_frame : frame_q;
  assign odd_frame = ~cur_frame[0];
  assign is_f      = (kind == POS_FBIT);

  always_comb begin
    if (mode_j1_i && cur_frame == LAST) align = yel_w;
    else                                align = align_bit(4'(cur_frame));
  end

  assign inv_sel = odd_frame ? pend[0] : pend[1];
  assign fbit    = align ^ inv_sel;
  assign hit[0]  = is_f & frm_en_i &  odd_frame & pend[0];
  assign hit[1]  = is_f & frm_en_i & ~odd_frame & pend[1];

  always_comb begin
    unique case (kind)
      POS_FBIT:  data_d = frm_en_i ? fbit : data_i;
      POS_MIMIC: data_d = (frm_en_i && mimic_en_i) ? f_last_q : data_i;
      POS_YEL:   data_d = (!mode_j1_i && yel_w) ? 1'b0 : data_i;
      default:   data_d = data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= 1'b0;
      f_last_q <= 1'b0;
    end else begin
      data_o <= data_d;
      if (is_f) f_last_q <= data_d;
    end
  end

endmodule

// File: rtl/sf_fbit_gen_chk.sv
module sf_fbit_gen_chk #(
  parameter int FRAME_BITS = 193,
  parameter int N_FRAMES   = 12,
  parameter int CH_BITS    = 8,
  localparam int CNT_W = $clog2(FRAME_BITS),
  localparam int FW    = $clog2(N_FRAMES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_rst_i,
  input logic             frame_strobe_i,
  input logic [CNT_W-1:0] bit_cnt_i,
  input logic             data_i,
  input logic             mode_j1_i,
  input logic             frm_en_i,
  input logic             mimic_en_i,
  input logic             yel_force_i,
  input logic             yel_auto_i,
  input logic             red_alarm_i,
  input logic             data_o,
  input logic [FW-1:0]    frame_q,
  input logic [FW-1:0]    cur_frame,
  input logic [1:0]       pend,
  input logic             f_last_q
);

  logic yel_c;
  logic b2_c;
  logic plain_c;
  logic f_c;

  assign yel_c   = yel_force_i | (yel_auto_i & red_alarm_i);
  assign f_c     = (bit_cnt_i == '0);
  assign b2_c    = (bit_cnt_i >= CNT_W'(2)) && (bit_cnt_i < CNT_W'(FRAME_BITS)) &&
                   (((32'(bit_cnt_i) - 1) % CH_BITS) == 1);
  assign plain_c = !f_c && (bit_cnt_i != CNT_W'(1)) && !b2_c;

  // R3
  t1_yel_bit2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_j1_i && yel_c && b2_c) |=> !data_o);

  // R11
  payload_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_c |=> (data_o == $past(data_i)));

  // R8
  fdis_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frm_en_i && f_c) |=> (data_o == $past(data_i)));

  // R2
  j1_f12_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_j1_i && frm_en_i && f_c && cur_frame == FW'(N_FRAMES - 1) && !pend[1])
      |=> (data_o == $past(yel_c)));

  // R7
  mimic_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_en_i && mimic_en_i && bit_cnt_i == CNT_W'(1)) |=> (data_o == $past(f_last_q)));

  // R9
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_strobe_i && !sync_rst_i && frame_q == FW'(N_FRAMES - 1)) |=> (frame_q == '0));

  // R9
  frame_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q < FW'(N_FRAMES));

  // R5
  ft_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[0] && !(f_c && frm_en_i && !cur_frame[0])) |=> pend[0]);

  // R6
  fs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[1] && !(f_c && frm_en_i && cur_frame[0])) |=> pend[1]);

endmodule

bind sf_fbit_gen sf_fbit_gen_chk #(
  .FRAME_BITS(FRAME_BITS), .N_FRAMES(N_FRAMES), .CH_BITS(CH_BITS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sync_rst_i    (sync_rst_i),
  .frame_strobe_i(frame_strobe_i),
  .bit_cnt_i     (bit_cnt_i),
  .data_i        (data_i),
  .mode_j1_i     (mode_j1_i),
  .frm_en_i      (frm_en_i),
  .mimic_en_i    (mimic_en_i),
  .yel_force_i   (yel_force_i),
  .yel_auto_i    (yel_auto_i),
  .red_alarm_i   (red_alarm_i),
  .data_o        (data_o),
  .frame_q       (frame_q),
  .cur_frame     (cur_frame),
  .pend          (pend),
  .f_last_q      (f_last_q)
);

// File: tb/sf_fbit_gen_tb.sv
module sf_fbit_gen_tb;

  localparam int FRAME_BITS = 193;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_rst_i = 1'b0;
  logic       frame_strobe_i = 1'b0;
  logic [7:0] bit_cnt_i = '0;
  logic       data_i = 1'b0;
  logic       mode_j1_i = 1'b0, frm_en_i = 1'b0, mimic_en_i = 1'b0;
  logic       yel_force_i = 1'b0, yel_auto_i = 1'b0, red_alarm_i = 1'b0;
  logic       ft_inv_i = 1'b0, fs_inv_i = 1'b0;
  logic       data_o;

  always #5 clk = ~clk;

  sf_fbit_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_rst_i(sync_rst_i),
    .frame_strobe_i(frame_strobe_i), .bit_cnt_i(bit_cnt_i), .data_i(data_i),
    .mode_j1_i(mode_j1_i), .frm_en_i(frm_en_i), .mimic_en_i(mimic_en_i),
    .yel_force_i(yel_force_i), .yel_auto_i(yel_auto_i), .red_alarm_i(red_alarm_i),
    .ft_inv_i(ft_inv_i), .fs_inv_i(fs_inv_i), .data_o(data_o)
  );

  typedef struct {
    logic  exp;
    string tag;
    int    fr;
    int    b;
  } item_t;

  item_t q[$];
  int    tests = 0;
  int    fails = 0;
  bit    done  = 1'b0;

  // configuration consumed by the driver at each bit
  logic  c_j1 = 0, c_en = 0, c_mimic = 0, c_force = 0, c_auto = 0, c_red = 0;
  logic  c_ft = 0, c_fs = 0;
  bit    c_sync = 0;
  string scen = "";

  // reference model state
  int    m_fr = 11;
  logic  m_pft = 0, m_pfs = 0, m_prev_ft = 0, m_prev_fs = 0, m_flast = 0;
  int    t1pat[12] = '{1, 0, 0, 0, 1, 1, 0, 1, 1, 1, 0, 0};

  task automatic drive_bit(input int b);
    logic  d, yel, e, inv, odd, al;
    string ptag;
    item_t it;
    @(negedge clk);
    d = 1'($urandom_range(0, 1));
    bit_cnt_i      = 8'(b);
    frame_strobe_i = (b == 0);
    data_i         = d;
    mode_j1_i = c_j1; frm_en_i = c_en; mimic_en_i = c_mimic;
    yel_force_i = c_force; yel_auto_i = c_auto; red_alarm_i = c_red;
    ft_inv_i = c_ft; fs_inv_i = c_fs;
    sync_rst_i = c_sync && (b == 5);
    yel = c_force | (c_auto & c_red);
    inv = 0;
    if (b == 0) begin
      m_fr = (m_fr + 1) % 12;
      al   = (c_j1 && m_fr == 11) ? yel : 1'(t1pat[m_fr]);
      odd  = (m_fr % 2 == 0);
      inv  = c_en && (odd ? m_pft : m_pfs);
      e    = c_en ? (al ^ inv) : d;
      m_flast = e;
      if (inv && odd)  m_pft = 0;
      if (inv && !odd) m_pfs = 0;
      ptag = !c_en ? "R8" : (c_j1 ? "R2" : "R1");
      if (inv) ptag = {ptag, odd ? " R5" : " R6"};
    end else if (b == 1) begin
      e    = (c_en && c_mimic) ? m_flast : d;
      ptag = (c_en && c_mimic) ? "R7" : "R8/R11";
    end else if (((b - 1) % 8) == 1) begin
      e    = (!c_j1 && yel) ? 1'b0 : d;
      ptag = (!c_j1 && yel) ? "R3" : "R11";
    end else begin
      e    = d;
      ptag = "R11";
    end
    if (c_ft && !m_prev_ft) m_pft = 1;
    if (c_fs && !m_prev_fs) m_pfs = 1;
    m_prev_ft = c_ft;
    m_prev_fs = c_fs;
    if (c_sync && b == 5) begin
      m_fr   = 11;
      c_sync = 0;
    end
    it.exp = e; it.tag = {ptag, " [", scen, "]"}; it.fr = m_fr + 1; it.b = b;
    q.push_back(it);
  endtask

  task automatic run_frames(input int n);
    for (int f = 0; f < n; f++)
      for (int b = 0; b < FRAME_BITS; b++) drive_bit(b);
  endtask

  // scoreboard monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        tests++;
        if (data_o !== it.exp) begin
          fails++;
          $display("FAIL %s frame %0d bit %0d: data_o=%0b expected %0b",
                   it.tag, it.fr, it.b, data_o, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (data_o !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: data_o=%0b expected 0", data_o);
    end
    rst_ni = 1'b1;

    c_en = 1; scen = "R1 R9 R11";                       run_frames(13);
    c_force = 1; scen = "R3 R4 force";                  run_frames(12);
    c_force = 0; c_auto = 1; scen = "R4 auto no red";   run_frames(12);
    c_red = 1; scen = "R3 R4 auto red";                 run_frames(12);
    c_red = 0; c_auto = 0;
    c_j1 = 1; scen = "R2 R11 J1";                       run_frames(12);
    c_force = 1; scen = "R2 R4 J1 yellow";              run_frames(12);
    c_force = 0; c_j1 = 0;
    c_ft = 1; scen = "R5 ft";                           run_frames(12);
    c_ft = 0; c_fs = 1; scen = "R6 fs";                 run_frames(12);
    c_fs = 0;                                           run_frames(1);
    c_ft = 1; c_fs = 1; scen = "R5 R6 both";            run_frames(12);
    c_ft = 0; c_fs = 0; run_frames(1);
    c_mimic = 1; c_ft = 1; scen = "R7 R5 mimic";        run_frames(12);
    c_ft = 0;
    c_en = 0; c_fs = 1; c_force = 1; scen = "R8 disabled"; run_frames(12);
    c_en = 1; c_fs = 0; c_force = 0; scen = "R8 R6 pending"; run_frames(12);
    c_mimic = 0;
    c_sync = 1; scen = "R9 sync";                       run_frames(14);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule